// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block takes in a stream of 32-bit configuration words, one word per accepted valid/ready transfer. It interprets them as a configuration packet processor would. Before synchronization it discards everything. The only exception is a two-word bus-width probe, which it notes in a sticky status flag. A fixed synchronization word moves it into the synchronized state. From then on it reads header packets.

A register-write header carries a register address and a word count, and the words that follow it come out one per cycle as register writes. A write header aimed at the frame-data register switches the parser into bulk mode. The payload length comes either from the header's own count or, when that count is zero, from a separate length word. Bulk words leave on their own data port, with a last flag on the final word.

A command write of the desync code sends the parser back to sync search. A malformed header does the same and also raises a sticky error flag. This lets a stream that holds several setup/payload/cleanup groups be handled one group after another.

Top module: `cfg_stream_parser`

## Requirements
- R1: While reset is high and on the first cycle after it, statSynced, statBusWidth, statError, regWrValid and bulkValid are all low. inReady is high whenever reset is low.
- R2: Before synchronization, no word produces a register write or a bulk word. This includes words shaped like headers.
- R3: The word 0x000000BB accepted directly before 0x11220044 sets statBusWidth, which then stays set until reset. The two words with another word between them do not set it.
- R4: Accepting 0xAA995566 while unsynchronized raises statSynced on the next cycle.
- R5: When synchronized and waiting for a header, the words 0xFFFFFFFF and 0x20000000 produce no output and change no state.
- R6: A write header has bits [31:29]=001 and bits [28:27]=10. Its register address sits in bits [17:13] and its word count N in bits [10:0]. The next N accepted words each pulse regWrValid for one cycle, on the cycle after acceptance, with that address and the word as data. A count of zero produces nothing.
- R7: A write header to register 2 with count 0 expects a length word next. The length word has bits [31:29]=010 and the count L in bits [26:0]. Any 0xFFFFFFFF words in between are skipped. The next L words leave on the bulk port, with bulkLast on the L-th word and no register writes.
- R8: A write header to register 2 with a nonzero count N sends the next N words to the bulk port, with bulkLast on the N-th word.
- R9: A write of 0x0000000D to register 4 (command) is emitted, and statSynced drops on the same cycle. Later headers are ignored until the sync word is seen again.
- R10: Any of the following sets the sticky statError and clears statSynced: a header whose bits [31:29] are not 001, a header opcode of 01 or 11, or a non-010 word where a length word is expected. A later sync word resumes normal parsing with statError still set.
- R11: Cycles with inValid low change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input configuration word |
| inReady | output | 1 | Parser accepts a word this cycle |
| regWrValid | output | 1 | Register write strobe |
| regWrAddr | output | 5 | Register address of the write |
| regWrData | output | 32 | Register write data |
| bulkValid | output | 1 | Bulk payload word valid |
| bulkData | output | 32 | Bulk payload word |
| bulkLast | output | 1 | Final bulk payload word |
| statSynced | output | 1 | Parser is synchronized |
| statBusWidth | output | 1 | Sticky bus-width probe detected |
| statError | output | 1 | Sticky malformed-header error |

## Verification
The assertions check these properties on every cycle:
- the register and bulk strobes are never active together;
- bulkLast only appears with bulkValid;
- the bus-width and error flags never clear outside reset;
- register and bulk outputs only follow a synchronized cycle;
- idle input cycles produce no output;
- a rise of statSynced is always caused by the sync word.

The bench's scenarios are needed for the rest, which is sequence behaviour:
- payload counting per header;
- the choice between the length word and the header count in bulk mode;
- the adjacency requirement of the bus-width probe;
- desync and error recovery across several die groups.

// File: rtl/cfg_parse_pkg.sv
`timescale 1ns/1ps
package cfg_parse_pkg;
  localparam int WORD_W   = 32;
  localparam int TYPE_LSB = 29;
  localparam int OP_LSB   = 27;
  localparam int ADDR_LSB = 13;

  localparam logic [WORD_W-1:0] WORD_PAD    = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] WORD_BWPRE  = 32'h0000_00BB;
  localparam logic [WORD_W-1:0] WORD_BWDET  = 32'h1122_0044;
  localparam logic [WORD_W-1:0] WORD_SYNC   = 32'hAA99_5566;
  localparam logic [WORD_W-1:0] WORD_DESYNC = 32'h0000_000D;

  localparam logic [2:0] TYPE_HDR = 3'b001;
  localparam logic [2:0] TYPE_LEN = 3'b010;
  localparam logic [1:0] OP_NOP   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b10;

  localparam int REG_CMD   = 4;
  localparam int REG_FRAME = 2;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_PAY, ST_LEN, ST_BULK
  } parseState_t;

  typedef struct packed {
    logic ldPay;
    logic decPay;
    logic ldBulkHdr;
    logic ldBulkLen;
    logic decBulk;
    logic emitReg;
    logic emitBulk;
    logic setErr;
    logic setBw;
  } dpCtl_t;
endpackage

// File: rtl/cfg_parse_ctrl.sv
`timescale 1ns/1ps
module cfg_parse_ctrl
  import cfg_parse_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int HCNT_W = 11,
  parameter int LEN_W  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordFire,
  input  logic [WORD_W-1:0] word,
  input  logic              payLast,
  input  logic              bulkEnd,
  input  logic              curIsCmd,
  output dpCtl_t            ctl,
  output logic              synced
);
  parseState_t st, stNxt;
  logic bwArmed, bwArmedNxt;

  logic [2:0]        hdrType;
  logic [1:0]        hdrOp;
  logic [ADDR_W-1:0] hdrAddr;
  logic              hdrCntZero;
  logic              lenZero;

  assign hdrType    = word[TYPE_LSB +: 3];
  assign hdrOp      = word[OP_LSB +: 2];
  assign hdrAddr    = word[ADDR_LSB +: ADDR_W];
  assign hdrCntZero = (word[HCNT_W-1:0] == '0);
  assign lenZero    = (word[LEN_W-1:0] == '0);

  always_comb begin
    ctl        = '0;
    stNxt      = st;
    bwArmedNxt = bwArmed;
    if (wordFire) begin
      case (st)
        ST_HUNT: begin
          bwArmedNxt = (word == WORD_BWPRE);
          if (bwArmed && word == WORD_BWDET) ctl.setBw = 1'b1;
          if (word == WORD_SYNC) stNxt = ST_HDR;
        end
        ST_HDR: begin
          if (word != WORD_PAD) begin
            if (hdrType != TYPE_HDR) begin
              ctl.setErr = 1'b1;
              stNxt      = ST_HUNT;
            end else if (hdrOp == OP_WRITE) begin
              if (hdrAddr == ADDR_W'(REG_FRAME)) begin
                if (hdrCntZero) stNxt = ST_LEN;
                else begin
                  ctl.ldBulkHdr = 1'b1;
                  stNxt         = ST_BULK;
                end
              end else if (!hdrCntZero) begin
                ctl.ldPay = 1'b1;
                stNxt     = ST_PAY;
              end
            end else if (hdrOp != OP_NOP) begin
              ctl.setErr = 1'b1;
              stNxt      = ST_HUNT;
            end
          end
        end
        ST_PAY: begin
          ctl.emitReg = 1'b1;
          ctl.decPay  = 1'b1;
          if (curIsCmd && word == WORD_DESYNC) stNxt = ST_HUNT;
          else if (payLast) stNxt = ST_HDR;
        end
        ST_LEN: begin
          if (word != WORD_PAD) begin
            if (hdrType != TYPE_LEN) begin
              ctl.setErr = 1'b1;
              stNxt      = ST_HUNT;
            end else if (lenZero) stNxt = ST_HDR;
            else begin
              ctl.ldBulkLen = 1'b1;
              stNxt         = ST_BULK;
            end
          end
        end
        ST_BULK: begin
          ctl.emitBulk = 1'b1;
          ctl.decBulk  = 1'b1;
          if (bulkEnd) stNxt = ST_HDR;
        end
        default: stNxt = ST_HUNT;
      endcase
    end
    if (stNxt != ST_HUNT) bwArmedNxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      bwArmed <= 1'b0;
    end else begin
      st      <= stNxt;
      bwArmed <= bwArmedNxt;
    end
  end

  assign synced = (st != ST_HUNT);
endmodule

// File: rtl/cfg_parse_dp.sv
`timescale 1ns/1ps
module cfg_parse_dp
  import cfg_parse_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int HCNT_W = 11,
  parameter int LEN_W  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  dpCtl_t            ctl,
  output logic              payLast,
  output logic              bulkEnd,
  output logic              curIsCmd,
  output logic              regWrValid,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [WORD_W-1:0] regWrData,
  output logic              bulkValid,
  output logic [WORD_W-1:0] bulkData,
  output logic              bulkLast,
  output logic              busWidthSeen,
  output logic              errSeen
);
  logic [HCNT_W-1:0] payCnt;
  logic [LEN_W-1:0]  bulkCnt;
  logic [ADDR_W-1:0] curAddr;

  assign payLast  = (payCnt == HCNT_W'(1));
  assign bulkEnd  = (bulkCnt == LEN_W'(1));
  assign curIsCmd = (curAddr == ADDR_W'(REG_CMD));

  always_ff @(posedge clk) begin
    if (rst) begin
      payCnt       <= '0;
      bulkCnt      <= '0;
      curAddr      <= '0;
      regWrValid   <= 1'b0;
      regWrAddr    <= '0;
      regWrData    <= '0;
      bulkValid    <= 1'b0;
      bulkData     <= '0;
      bulkLast     <= 1'b0;
      busWidthSeen <= 1'b0;
      errSeen      <= 1'b0;
    end else begin
      if (ctl.ldPay) begin
        payCnt  <= word[HCNT_W-1:0];
        curAddr <= word[ADDR_LSB +: ADDR_W];
      end else if (ctl.decPay) begin
        payCnt <= payCnt - 1'b1;
      end
      if (ctl.ldBulkHdr)      bulkCnt <= LEN_W'(word[HCNT_W-1:0]);
      else if (ctl.ldBulkLen) bulkCnt <= word[LEN_W-1:0];
      else if (ctl.decBulk)   bulkCnt <= bulkCnt - 1'b1;

      regWrValid <= ctl.emitReg;
      if (ctl.emitReg) begin
        regWrAddr <= curAddr;
        regWrData <= word;
      end
      bulkValid <= ctl.emitBulk;
      bulkLast  <= ctl.emitBulk && bulkEnd;
      if (ctl.emitBulk) bulkData <= word;

      if (ctl.setBw)  busWidthSeen <= 1'b1;
      if (ctl.setErr) errSeen      <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_parser.sv
`timescale 1ns/1ps
module cfg_stream_parser
  import cfg_parse_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int HCNT_W = 11,
  parameter int LEN_W  = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [31:0]       inData,
  output logic              inReady,
  output logic              regWrValid,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [31:0]       regWrData,
  output logic              bulkValid,
  output logic [31:0]       bulkData,
  output logic              bulkLast,
  output logic              statSynced,
  output logic              statBusWidth,
  output logic              statError
);
  dpCtl_t ctl;
  logic   wordFire, payLast, bulkEnd, curIsCmd;

  assign inReady  = ~rst;
  assign wordFire = inValid & inReady;

  cfg_parse_ctrl #(.ADDR_W(ADDR_W), .HCNT_W(HCNT_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rst(rst), .wordFire(wordFire), .word(inData),
    .payLast(payLast), .bulkEnd(bulkEnd), .curIsCmd(curIsCmd),
    .ctl(ctl), .synced(statSynced)
  );

  cfg_parse_dp #(.ADDR_W(ADDR_W), .HCNT_W(HCNT_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rst(rst), .word(inData), .ctl(ctl),
    .payLast(payLast), .bulkEnd(bulkEnd), .curIsCmd(curIsCmd),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .bulkValid(bulkValid), .bulkData(bulkData), .bulkLast(bulkLast),
    .busWidthSeen(statBusWidth), .errSeen(statError)
  );
endmodule

// File: rtl/cfg_stream_parser_chk.sv
`timescale 1ns/1ps
module cfg_stream_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] inData,
  input logic        regWrValid,
  input logic        bulkValid,
  input logic        bulkLast,
  input logic        statSynced,
  input logic        statBusWidth,
  input logic        statError
);
  a_r7_single_sink: assert property (@(posedge clk) disable iff (rst)
    !(regWrValid && bulkValid));

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    bulkLast |-> bulkValid);

  a_r3_bw_sticky: assert property (@(posedge clk) disable iff (rst)
    statBusWidth |=> statBusWidth);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    statError |=> statError);

  a_r2_write_needs_sync: assert property (@(posedge clk) disable iff (rst)
    regWrValid |-> $past(statSynced));

  a_r8_bulk_needs_sync: assert property (@(posedge clk) disable iff (rst)
    bulkValid |-> ($past(statSynced) && statSynced));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |-> (!regWrValid && !bulkValid));

  a_r4_sync_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(statSynced) |-> ($past(inValid) && $past(inData) == 32'hAA99_5566));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
  .regWrValid(regWrValid), .bulkValid(bulkValid), .bulkLast(bulkLast),
  .statSynced(statSynced), .statBusWidth(statBusWidth), .statError(statError)
);

// File: tb/tb_cfg_stream_parser.sv
`timescale 1ns/1ps
module tb_cfg_stream_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady, regWrValid, bulkValid, bulkLast;
  logic [4:0]  regWrAddr;
  logic [31:0] regWrData, bulkData;
  logic        statSynced, statBusWidth, statError;

  always #4 clk = ~clk;

  cfg_stream_parser dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .bulkValid(bulkValid), .bulkData(bulkData), .bulkLast(bulkLast),
    .statSynced(statSynced), .statBusWidth(statBusWidth), .statError(statError)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state: 0 hunt, 1 header, 2 reg payload, 3 length, 4 bulk
  int mSt = 0, mRem = 0, mAddr = 0;
  bit mArm = 0, mBw = 0, mErr = 0;
  bit exRegV = 0, exBV = 0, exBL = 0;
  int exRegA = 0;
  logic [31:0] exRegD = '0, exBD = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelWord(input logic [31:0] w);
    exRegV = 0; exBV = 0; exBL = 0;
    case (mSt)
      0: begin
        if (mArm && w == 32'h1122_0044) mBw = 1;
        mArm = (w == 32'h0000_00BB);
        if (w == 32'hAA99_5566) begin mSt = 1; mArm = 0; end
      end
      1: if (w != 32'hFFFF_FFFF) begin
        if (w[31:29] != 3'd1 || w[28:27] == 2'd1 || w[28:27] == 2'd3) begin
          mErr = 1; mSt = 0;
        end else if (w[28:27] == 2'd2) begin
          if (w[17:13] == 2) begin
            if (w[10:0] == 0) mSt = 3;
            else begin mRem = w[10:0]; mSt = 4; end
          end else if (w[10:0] != 0) begin
            mRem = w[10:0]; mAddr = w[17:13]; mSt = 2;
          end
        end
      end
      2: begin
        exRegV = 1; exRegA = mAddr; exRegD = w;
        mRem--;
        if (mAddr == 4 && w == 32'hD) mSt = 0;
        else if (mRem == 0) mSt = 1;
      end
      3: if (w != 32'hFFFF_FFFF) begin
        if (w[31:29] != 3'd2) begin mErr = 1; mSt = 0; end
        else if (w[26:0] == 0) mSt = 1;
        else begin mRem = w[26:0]; mSt = 4; end
      end
      default: begin
        exBV = 1; exBD = w; mRem--;
        exBL = (mRem == 0);
        if (mRem == 0) mSt = 1;
      end
    endcase
  endtask

  task automatic compareAll(input string tag);
    chk(regWrValid == exRegV, {tag, " regWrValid"}, regWrValid, exRegV);
    if (exRegV) begin
      chk(regWrAddr == exRegA[4:0], {tag, " regWrAddr"}, regWrAddr, exRegA);
      chk(regWrData == exRegD, {tag, " regWrData"}, regWrData, exRegD);
    end
    chk(bulkValid == exBV, {tag, " bulkValid"}, bulkValid, exBV);
    chk(bulkLast == exBL, {tag, " bulkLast"}, bulkLast, exBL);
    if (exBV) chk(bulkData == exBD, {tag, " bulkData"}, bulkData, exBD);
    chk(statSynced == (mSt != 0), {tag, " statSynced"}, statSynced, mSt != 0);
    chk(statBusWidth == mBw, {tag, " statBusWidth"}, statBusWidth, mBw);
    chk(statError == mErr, {tag, " statError"}, statError, mErr);
    chk(inReady == 1'b1, {tag, " R1 inReady"}, inReady, 1);
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    inValid = 1'b1; inData = w;
    @(posedge clk); #2;
    modelWord(w);
    compareAll(tag);
  endtask

  task automatic idle(input logic [31:0] junk, input string tag);
    inValid = 1'b0; inData = junk;
    @(posedge clk); #2;
    exRegV = 0; exBV = 0; exBL = 0;
    compareAll(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(!statSynced && !statBusWidth && !statError, "R1 flags in reset",
        {statSynced, statBusWidth, statError}, 0);
    chk(!regWrValid && !bulkValid, "R1 strobes in reset", {regWrValid, bulkValid}, 0);
    rst = 1'b0;
    idle(32'h0, "R1 after reset");

    // R2 headers before sync are ignored
    send(32'h3000_8001, "R2");
    send(32'h0000_0007, "R2");
    send(32'h3000_4000, "R2");
    send(32'h4000_0002, "R2");

    // R3 probe with a gap does not count, adjacent pair does
    send(32'h0000_00BB, "R3");
    send(32'hFFFF_FFFF, "R3");
    send(32'h1122_0044, "R3");
    chk(!statBusWidth, "R3 gapped probe", statBusWidth, 0);
    send(32'h0000_00BB, "R3");
    send(32'h1122_0044, "R3");
    chk(statBusWidth, "R3 adjacent probe", statBusWidth, 1);

    // R11 idle cycles with the sync word on the bus
    idle(32'hAA99_5566, "R11");
    idle(32'hAA99_5566, "R11");
    chk(!statSynced, "R11 idle sync ignored", statSynced, 0);

    // R4 sync
    send(32'hFFFF_FFFF, "R4");
    send(32'hAA99_5566, "R4");
    chk(statSynced, "R4 synced", statSynced, 1);

    // R5 padding and no-op headers
    send(32'h2000_0000, "R5");
    send(32'hFFFF_FFFF, "R5");
    send(32'h2000_0000, "R5");

    // R6 register writes
    send(32'h3000_8001, "R6");
    send(32'h0000_0007, "R6");
    send(32'h3002_2001, "R6");
    send(32'h0000_0000, "R6");
    send(32'h3000_2003, "R6");
    send(32'h1111_0001, "R6");
    idle(32'h0, "R11 mid payload");
    send(32'hFFFF_FFFF, "R6");
    send(32'h3333_0003, "R6");
    chk(regWrValid && regWrAddr == 5'd1 && regWrData == 32'h3333_0003,
        "R6 third payload word", regWrData, 32'h3333_0003);
    send(32'h3001_2000, "R6");
    send(32'h2000_0000, "R6");

    // R7 frame-data with a length word
    send(32'h3000_4000, "R7");
    send(32'hFFFF_FFFF, "R7");
    send(32'h4000_0003, "R7");
    send(32'hABCD_0001, "R7");
    send(32'hFFFF_FFFF, "R7");
    send(32'hABCD_0003, "R7");
    chk(bulkValid && bulkLast && bulkData == 32'hABCD_0003, "R7 last word",
        {bulkValid, bulkLast}, 3);
    send(32'h2000_0000, "R7");

    // R8 frame-data with a count in the header
    send(32'h3000_4002, "R8");
    send(32'h5555_0001, "R8");
    send(32'h5555_0002, "R8");
    send(32'h3000_8001, "R8");
    send(32'h0000_0001, "R8");

    // R9 desync then a second group
    send(32'h3000_8001, "R9");
    send(32'h0000_000D, "R9");
    chk(regWrValid && !statSynced, "R9 desync write", {regWrValid, statSynced}, 2);
    send(32'h3000_8001, "R9");
    send(32'h0000_0007, "R9");
    send(32'hAA99_5566, "R9");
    send(32'h3000_4000, "R9");
    send(32'h4000_0002, "R9");
    send(32'h7777_0001, "R9");
    send(32'h7777_0002, "R9");
    send(32'h3000_8001, "R9");
    send(32'h0000_000D, "R9");

    // R10 error cases and recovery
    send(32'hAA99_5566, "R10");
    send(32'h1000_0000, "R10");
    chk(statError && !statSynced, "R10 bad type", {statError, statSynced}, 2);
    send(32'hAA99_5566, "R10");
    send(32'h2800_0000, "R10");
    send(32'hAA99_5566, "R10");
    send(32'h3800_8001, "R10");
    send(32'hAA99_5566, "R10");
    send(32'h3000_4000, "R10");
    send(32'h3000_0000, "R10");
    send(32'hAA99_5566, "R10");
    send(32'h3000_8001, "R10");
    send(32'h0000_0005, "R10");
    chk(regWrValid && statError, "R10 recovery", {regWrValid, statError}, 3);

    idle(32'h0, "R11 end");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule